// File: doc/BRIEF.md
# Crosstalk Victim/Aggressor Test Pair Sequencer

This block walks through the complete set of worst-case crosstalk tests for a bus of `WIDTH` parallel wires. Each test singles out one wire as the victim. It drives every other wire as an aggressor and produces a pair of vectors. The first vector sets up the wires. The second vector carries the transition that excites the fault. Four fault kinds exist for each victim: positive glitch, negative glitch, rising delay and falling delay. When the bus carries data both ways, every test is issued once for each direction, so the sequence holds `4*WIDTH*(BIDIR+1)` pairs.

Pairs leave on a valid/ready stream. A pair is presented while `pair_valid` is high and is consumed on a cycle where `pair_ready` is also high. The consumer may hold `pair_ready` low for as long as it likes; the presented pair then stays frozen. A plain `start` pulse launches a pass from idle. A one-cycle `done` pulse closes it.

Alongside the stream sits a response compactor. The second vectors seen at the far end of the bus are added into an accumulator. Each rising-delay second vector is one-hot on its victim line. If the observed rising-delay words of one direction are summed, the result is all ones when every line passes, and each zero bit names a failing line.

Top module: `mat_gen`

## Requirements
- R1: After reset, `pair_valid` and `done` are low and `acc_sum` is zero.
- R2: A `start` pulse while idle makes `pair_valid` rise in the next cycle. The first pair presented is victim 0, fault code 0, direction 0.
- R3: Pairs follow a fixed order. Victim index (bit position, so line k is bit k-1) counts 0 to WIDTH-1 as the outermost level. Inside each victim, fault codes run 0 = positive glitch, 1 = negative glitch, 2 = rising delay, 3 = falling delay. Inside each fault, direction runs 0 then 1 when `BIDIR`=1; otherwise direction is always 0. The pass holds exactly 4*WIDTH*(BIDIR+1) pairs, so 64 for 8 bidirectional wires and 48 for 12 one-way wires.
- R4: For a positive glitch (code 0), v1 is all zeros. v2 is all ones except a 0 at the victim bit.
- R5: For a negative glitch (code 1), v1 is all ones. v2 is zero except a 1 at the victim bit.
- R6: For a rising delay (code 2), v1 is all ones except a 0 at the victim bit, and v2 is its bitwise inverse.
- R7: For a falling delay (code 3), v1 is zero except a 1 at the victim bit, and v2 is its bitwise inverse.
- R8: While `pair_valid` is high and `pair_ready` is low, `pair_valid` stays high and all pair fields hold their values into the next cycle.
- R9: `done` is high for exactly one cycle, in the cycle after the last pair is consumed. `pair_valid` is low from that cycle on.
- R10: `start` has no effect on the sequence or the accumulator while a pass is running or while `done` is high.
- R11: An accepted `start` (idle only) clears `acc_sum` in the next cycle. This clear takes priority over an `obs_valid` in the same cycle.
- R12: In any other cycle with `obs_valid` high, `acc_sum` becomes `acc_sum + obs_data` modulo 2^WIDTH; with `obs_valid` low it holds. When only the rising-delay v2 words of one direction are added, a clean bus leaves all ones, and a line whose word arrives as zero leaves a 0 at its bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a pass when idle |
| pair_valid | output | 1 | A test pair is presented |
| pair_ready | input | 1 | Consumer takes the presented pair |
| pair_v1 | output | WIDTH | Setup vector |
| pair_v2 | output | WIDTH | Exciting vector |
| pair_victim | output | $clog2(WIDTH) | Victim bit index |
| pair_fault | output | 2 | Fault code 0..3 |
| pair_dir | output | 1 | Bus direction tag for v2 |
| done | output | 1 | One-cycle end-of-pass pulse |
| obs_valid | input | 1 | Observed v2 word is present |
| obs_data | input | WIDTH | Observed v2 word from the far end |
| acc_sum | output | WIDTH | Compacted response |

## Verification
The shape of every presented pair is checked on every cycle against its fault code. The same goes for the freezing of a stalled pair, the first pair after a start, the single-cycle `done` and its link to the final pair, and the arithmetic of the accumulator. Only the bench's scenarios can show the full ordering and count of a pass, and that a mid-pass start leaves the sequence and sum alone. They also show that a clean run compacts to all ones and that a corrupted line shows up as the matching zero bit. Random back-pressure exercises the stall behaviour across many pair boundaries.

// File: rtl/mat_pkg.sv
package mat_pkg;

  // Fault kinds, in the order they are issued for each victim
  typedef enum logic [1:0] {
    FLT_PGLITCH = 2'd0,
    FLT_NGLITCH = 2'd1,
    FLT_RDELAY  = 2'd2,
    FLT_FDELAY  = 2'd3
  } flt_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } st_e;

endpackage

// File: rtl/mat_seq.sv
// Walks victim / fault / direction counters in nested order.
module mat_seq
  import mat_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter bit BIDIR = 1'b1,
  localparam int VW = $clog2(WIDTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  output logic [VW-1:0] victim,
  output flt_e          fault,
  output logic          dir,
  output logic          last
);

  localparam logic [VW-1:0] LAST_VIC = VW'(WIDTH - 1);

  logic [VW-1:0] vic_q;
  flt_e          flt_q;
  logic          dir_wrap;
  logic          flt_wrap;
  logic          vic_end;

  assign flt_wrap = (flt_q == FLT_FDELAY);
  assign vic_end  = (vic_q == LAST_VIC);

  // Direction is the innermost level; it only exists on a two-way bus
  generate
    if (BIDIR) begin : g_two_way
      logic dir_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      dir_q <= 1'b0;
        else if (clear)  dir_q <= 1'b0;
        else if (step)   dir_q <= ~dir_q;
      end
      assign dir_wrap = dir_q;
      assign dir      = dir_q;
    end else begin : g_one_way
      assign dir_wrap = 1'b1;
      assign dir      = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vic_q <= '0;
      flt_q <= FLT_PGLITCH;
    end else if (clear) begin
      vic_q <= '0;
      flt_q <= FLT_PGLITCH;
    end else if (step && dir_wrap) begin
      if (flt_wrap) begin
        flt_q <= FLT_PGLITCH;
        vic_q <= vic_end ? '0 : vic_q + 1'b1;
      end else begin
        flt_q <= flt_e'(flt_q + 2'd1);
      end
    end
  end

  assign victim = vic_q;
  assign fault  = flt_q;
  assign last   = vic_end && flt_wrap && dir_wrap;

endmodule

// File: rtl/mat_vec.sv
// Builds the two vectors of a test from victim index and fault kind.
module mat_vec
  import mat_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int VW = $clog2(WIDTH)
) (
  input  logic [VW-1:0]    victim,
  input  flt_e             fault,
  output logic [WIDTH-1:0] v1,
  output logic [WIDTH-1:0] v2
);

  logic [WIDTH-1:0] hot;

  // One-hot mask of the victim wire
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_hot
      assign hot[i] = (victim == VW'(i));
    end
  endgenerate

  always_comb begin
    unique case (fault)
      FLT_PGLITCH: begin v1 = '0;   v2 = ~hot; end  // victim low, others rise
      FLT_NGLITCH: begin v1 = '1;   v2 = hot;  end  // victim high, others fall
      FLT_RDELAY:  begin v1 = ~hot; v2 = hot;  end  // victim rises, others fall
      default:     begin v1 = hot;  v2 = ~hot; end  // victim falls, others rise
    endcase
  end

endmodule

// File: rtl/mat_acc.sv
// Additive response compactor.
module mat_acc #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add_en,
  input  logic [WIDTH-1:0] add_val,
  output logic [WIDTH-1:0] sum
);

  logic [WIDTH-1:0] sum_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sum_q <= '0;
    else if (clr)    sum_q <= '0;       // clear wins over an add
    else if (add_en) sum_q <= sum_q + add_val;
  end

  assign sum = sum_q;

endmodule

// File: rtl/mat_gen.sv
module mat_gen
  import mat_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter bit BIDIR = 1'b1,
  localparam int VW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             pair_valid,
  input  logic             pair_ready,
  output logic [WIDTH-1:0] pair_v1,
  output logic [WIDTH-1:0] pair_v2,
  output logic [VW-1:0]    pair_victim,
  output logic [1:0]       pair_fault,
  output logic             pair_dir,
  output logic             done,
  input  logic             obs_valid,
  input  logic [WIDTH-1:0] obs_data,
  output logic [WIDTH-1:0] acc_sum
);

  st_e           st_q;
  logic          start_ok;
  logic          xfer;
  logic          seq_last;
  logic [VW-1:0] vic;
  flt_e          flt;
  logic          dir;

  assign start_ok = start && (st_q == ST_IDLE);
  assign xfer     = (st_q == ST_RUN) && pair_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else begin
      unique case (st_q)
        ST_IDLE: if (start_ok)         st_q <= ST_RUN;
        ST_RUN:  if (xfer && seq_last) st_q <= ST_DONE;
        default:                       st_q <= ST_IDLE;
      endcase
    end
  end

  mat_seq #(.WIDTH(WIDTH), .BIDIR(BIDIR)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (start_ok),
    .step   (xfer),
    .victim (vic),
    .fault  (flt),
    .dir    (dir),
    .last   (seq_last)
  );

  mat_vec #(.WIDTH(WIDTH)) u_vec (
    .victim (vic),
    .fault  (flt),
    .v1     (pair_v1),
    .v2     (pair_v2)
  );

  mat_acc #(.WIDTH(WIDTH)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (start_ok),
    .add_en  (obs_valid),
    .add_val (obs_data),
    .sum     (acc_sum)
  );

  assign pair_valid  = (st_q == ST_RUN);
  assign pair_victim = vic;
  assign pair_fault  = flt;
  assign pair_dir    = dir;
  assign done        = (st_q == ST_DONE);

endmodule

// File: rtl/mat_gen_chk.sv
module mat_gen_chk #(
  parameter int WIDTH = 8,
  parameter bit BIDIR = 1'b1,
  localparam int VW = $clog2(WIDTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             pair_valid,
  input logic             pair_ready,
  input logic [WIDTH-1:0] pair_v1,
  input logic [WIDTH-1:0] pair_v2,
  input logic [VW-1:0]    pair_victim,
  input logic [1:0]       pair_fault,
  input logic             pair_dir,
  input logic             done,
  input logic             obs_valid,
  input logic [WIDTH-1:0] obs_data,
  input logic [WIDTH-1:0] acc_sum
);

  localparam logic [VW-1:0] LAST_V = VW'(WIDTH - 1);

  logic kick;
  assign kick = start && !pair_valid && !done;

  // R2
  start_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (pair_valid && pair_victim == '0 && pair_fault == 2'd0 && !pair_dir));

  // R8
  hold_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && !pair_ready) |=> (pair_valid && $stable(pair_v1) && $stable(pair_v2)
      && $stable(pair_victim) && $stable(pair_fault) && $stable(pair_dir)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(pair_valid && pair_ready) && $past(pair_victim) == LAST_V
      && $past(pair_fault) == 2'd3 && !pair_valid));

  // R4
  pglitch_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && pair_fault == 2'd0) |->
      (pair_v1 == '0 && !pair_v2[pair_victim] && $countones(pair_v2) == WIDTH - 1));

  // R5
  nglitch_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && pair_fault == 2'd1) |->
      (pair_v1 == '1 && pair_v2[pair_victim] && $countones(pair_v2) == 1));

  // R6
  rdelay_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && pair_fault == 2'd2) |->
      (!pair_v1[pair_victim] && $countones(pair_v1) == WIDTH - 1 && pair_v2 == ~pair_v1));

  // R7
  fdelay_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && pair_fault == 2'd3) |->
      (!pair_v2[pair_victim] && $countones(pair_v2) == WIDTH - 1 && pair_v1 == ~pair_v2));

  // R11
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (acc_sum == '0));

  // R12
  acc_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (obs_valid && !kick) |=> (acc_sum == WIDTH'($past(acc_sum) + $past(obs_data))));

  // R12
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!obs_valid && !kick) |=> $stable(acc_sum));

  // R3
  dir_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && !BIDIR) |-> !pair_dir);

endmodule

bind mat_gen mat_gen_chk #(.WIDTH(WIDTH), .BIDIR(BIDIR)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .pair_valid  (pair_valid),
  .pair_ready  (pair_ready),
  .pair_v1     (pair_v1),
  .pair_v2     (pair_v2),
  .pair_victim (pair_victim),
  .pair_fault  (pair_fault),
  .pair_dir    (pair_dir),
  .done        (done),
  .obs_valid   (obs_valid),
  .obs_data    (obs_data),
  .acc_sum     (acc_sum)
);

// File: tb/sim_mat_gen.sv
module sim_mat_gen;

  localparam int W0 = 8;
  localparam int T0 = 4 * W0 * 2;
  localparam int W1 = 12;
  localparam int T1 = 4 * W1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;

  // u0: 8 wires, two-way
  logic          s0_start = 0, s0_ready = 0, s0_obs_v = 0;
  logic [W0-1:0] s0_obs_d = '0;
  logic          o0_valid, o0_dir, o0_done;
  logic [W0-1:0] o0_v1, o0_v2, o0_acc;
  logic [2:0]    o0_vic;
  logic [1:0]    o0_flt;

  mat_gen #(.WIDTH(W0), .BIDIR(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .start(s0_start),
    .pair_valid(o0_valid), .pair_ready(s0_ready),
    .pair_v1(o0_v1), .pair_v2(o0_v2), .pair_victim(o0_vic),
    .pair_fault(o0_flt), .pair_dir(o0_dir), .done(o0_done),
    .obs_valid(s0_obs_v), .obs_data(s0_obs_d), .acc_sum(o0_acc)
  );

  // u1: 12 wires, one-way
  logic          s1_start = 0, s1_ready = 0;
  logic          o1_valid, o1_dir, o1_done;
  logic [W1-1:0] o1_v1, o1_v2, o1_acc;
  logic [3:0]    o1_vic;
  logic [1:0]    o1_flt;

  mat_gen #(.WIDTH(W1), .BIDIR(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .start(s1_start),
    .pair_valid(o1_valid), .pair_ready(s1_ready),
    .pair_v1(o1_v1), .pair_v2(o1_v2), .pair_victim(o1_vic),
    .pair_fault(o1_flt), .pair_dir(o1_dir), .done(o1_done),
    .obs_valid(1'b0), .obs_data('0), .acc_sum(o1_acc)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected vector of a test, from the fault rules
  function automatic logic [63:0] want_v(input int w, input int vic, input int flt, input bit second);
    logic [63:0] all1, m, a, b;
    all1 = (64'd1 << w) - 64'd1;
    m    = 64'd1 << vic;
    case (flt)
      0:       begin a = 64'd0;     b = all1 & ~m; end
      1:       begin a = all1;      b = m;         end
      2:       begin a = all1 & ~m; b = m;         end
      default: begin a = m;         b = all1 & ~m; end
    endcase
    return second ? b : a;
  endfunction

  // One full pass on u0 with random back-pressure.
  // bad_line: rising-delay word of this line returns as zero (-1: none)
  task automatic run0(input int bad_line, input bit poke_start, input logic [W0-1:0] want_acc);
    int k = 0;
    int guard = 0;
    bit stalled = 0;
    bit pend = 0;
    logic [W0-1:0] pend_d = '0;
    logic [63:0] prev;
    // start together with an observation: clear must win
    s0_start = 1; s0_obs_v = 1; s0_obs_d = 8'h11;
    @(negedge clk);
    s0_start = 0; s0_obs_v = 0;
    chk("R11 clear beats add", 64'(o0_acc), 64'd0);
    chk("R2 valid after start", 64'(o0_valid), 64'd1);
    chk("R2 first victim", 64'(o0_vic), 64'd0);
    prev = '0;
    while (k < T0 && guard < 5000) begin
      s0_obs_v = pend; s0_obs_d = pend_d; pend = 0;
      if (stalled)
        chk("R8 stalled pair frozen", {o0_v1, o0_v2, 8'(o0_vic), 8'(o0_flt), 8'(o0_dir)}, prev);
      chk("R3 valid during pass", 64'(o0_valid), 64'd1);
      chk("R9 no early done", 64'(o0_done), 64'd0);
      s0_ready = ($urandom % 4) != 0;
      s0_start = poke_start && (k == 20);
      if (o0_valid && s0_ready) begin
        chk("R3 victim order", 64'(o0_vic), 64'(k / 8));
        chk("R3 fault order", 64'(o0_flt), 64'((k / 2) % 4));
        chk("R3 direction order", 64'(o0_dir), 64'(k % 2));
        case (o0_flt)
          2'd0: begin chk("R4 v1", 64'(o0_v1), want_v(W0, k/8, 0, 0)); chk("R4 v2", 64'(o0_v2), want_v(W0, k/8, 0, 1)); end
          2'd1: begin chk("R5 v1", 64'(o0_v1), want_v(W0, k/8, 1, 0)); chk("R5 v2", 64'(o0_v2), want_v(W0, k/8, 1, 1)); end
          2'd2: begin chk("R6 v1", 64'(o0_v1), want_v(W0, k/8, 2, 0)); chk("R6 v2", 64'(o0_v2), want_v(W0, k/8, 2, 1)); end
          default: begin chk("R7 v1", 64'(o0_v1), want_v(W0, k/8, 3, 0)); chk("R7 v2", 64'(o0_v2), want_v(W0, k/8, 3, 1)); end
        endcase
        if (o0_flt == 2'd2 && !o0_dir) begin
          pend = 1;
          pend_d = (int'(o0_vic) == bad_line) ? '0 : o0_v2;
        end
        k++;
      end
      stalled = o0_valid && !s0_ready;
      prev = {o0_v1, o0_v2, 8'(o0_vic), 8'(o0_flt), 8'(o0_dir)};
      @(negedge clk);
      guard++;
    end
    s0_obs_v = pend; s0_obs_d = pend_d; s0_ready = 0; s0_start = 0;
    chk("R3 pair count", 64'(k), 64'(T0));
    chk("R9 done after last pair", 64'(o0_done), 64'd1);
    chk("R9 valid low at done", 64'(o0_valid), 64'd0);
    @(negedge clk);
    s0_obs_v = 0;
    chk("R9 done one cycle", 64'(o0_done), 64'd0);
    @(negedge clk);
    chk("R12 R10 compacted sum", 64'(o0_acc), 64'(want_acc));
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin : main
    int k;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", 64'(o0_valid), 64'd0);
    chk("R1 done", 64'(o0_done), 64'd0);
    chk("R1 acc", 64'(o0_acc), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", 64'(o0_valid), 64'd0);

    // Clean pass: all ones
    run0(-1, 1'b0, 8'hFF);

    // Idle adds wrap modulo 2^WIDTH
    s0_obs_v = 1; s0_obs_d = 8'h03;
    @(negedge clk);
    s0_obs_d = 8'h04;
    @(negedge clk);
    s0_obs_v = 0;
    chk("R12 add wraps", 64'(o0_acc), 64'h06);
    @(negedge clk);
    chk("R12 holds without strobe", 64'(o0_acc), 64'h06);

    // Line 6 (bit 5) fails, and a start is poked mid-pass (R10)
    run0(5, 1'b1, 8'hDF);

    // Pass with another faulty line, random back-pressure again
    run0(0, 1'b0, 8'hFE);

    // One-way 12-wire instance: count and directed vectors
    s1_start = 1;
    @(negedge clk);
    s1_start = 0;
    s1_ready = 1;
    k = 0;
    while (!o1_done && k < 200) begin
      if (o1_valid) begin
        if (k == 12) begin
          chk("R4 line 4 v1", 64'(o1_v1), 64'h000);
          chk("R4 line 4 v2", 64'(o1_v2), 64'hFF7);
        end
        if (k == 19) begin
          chk("R7 line 5 v1", 64'(o1_v1), 64'h010);
          chk("R7 line 5 v2", 64'(o1_v2), 64'hFEF);
        end
        if (o1_dir) chk("R3 one-way dir", 64'(o1_dir), 64'd0);
        k++;
      end
      @(negedge clk);
    end
    s1_ready = 0;
    chk("R3 one-way pair count", 64'(k), 64'(T1));

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule